// File: doc/BRIEF.md
# Tagged HDLC Transmit Queue

This block is the staging queue between a host register port and a transmit HDLC framer. The host writes bytes for outgoing frames. Each byte carries a one-bit tag that marks the last byte of a message. The framer pulls bytes one at a time from the head of the queue. When a byte is tagged, the framer knows the message is complete and can append the check sequence and closing flags. The serial framing itself lies outside this block.

The host port works with either a 16-bit or an 8-bit bus. On the wide bus, one write carries the byte and its tag together. On the narrow bus, the host first writes the low byte and then the high byte. Only the high-byte write commits the entry. The host side has no stall: `wr_ready` only reports whether a commit would be taken, and a commit made while it is low is dropped. The framer side is valid/ready. `rd_valid` means a head entry is presented on `rd_data`/`rd_eom`, and an entry is consumed in any cycle where both `rd_valid` and `rd_ready` are high. If the framer raises `rd_ready` while the queue is empty, that counts as an underrun.

The status side has four outputs. `pkt_end` is a latched event that is cleared by a status read. `low_wm` is a live low-watermark flag, `empty` is a live empty flag, and `fill_lvl` is a coarse fill level. Each status source has its own interrupt mask, and a global mask gates the `irq` output as a whole.

Top module: `hdlc_tx_fifo`

## Requirements
- R1: The queue holds up to 256 entries of 8 data bits plus 1 tag bit, returned in write order. While `rd_valid` is 1, `rd_data`/`rd_eom` show the oldest entry, and a pop moves them to the next entry after the clock edge.
- R2: When 256 entries are held, `wr_ready` is 0 and any commit is discarded with no entry overwritten. If a pop and a commit happen in the same cycle while full, the pop is taken and the commit is discarded.
- R3: With `bus8`=0, a write (`wr_valid`=1) commits one entry: data is `wr_data[7:0]`, tag is `wr_data[8]`, and `wr_data[15:9]` is ignored.
- R4: With `bus8`=1, a write with `wr_hi`=0 only loads `wr_data[7:0]` into a holding byte and commits nothing. A write with `wr_hi`=1 commits the holding byte, with tag `wr_data[0]`.
- R5: `pkt_end` becomes 1 after the clock edge at which a tagged entry is popped, or at which `rd_ready` is 1 while the queue is empty (underrun).
- R6: `stat_rd`=1 clears `pkt_end` after the clock edge. If a new set condition occurs in the same cycle, the set wins and `pkt_end` stays 1.
- R7: `low_wm` is 1 exactly when the entry count is below 16 × (`wm_sel` + 1). It follows the count and `wm_sel` without latching.
- R8: `empty` is 1 exactly when the count is 0. `fill_lvl` equals count / 16 (integer division), saturated at 15.
- R9: `irq` = `mask_global` AND ((`pkt_end` AND `mask_pkt_end`) OR (`low_wm` AND `mask_low_wm`)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus8 | input | 1 | 1 selects narrow (two-write) host mode |
| wr_valid | input | 1 | Host write strobe |
| wr_hi | input | 1 | Narrow mode: 1 = high-byte write (commits) |
| wr_data | input | 16 | Host write word |
| wr_ready | output | 1 | 1 when a commit will be accepted |
| rd_valid | output | 1 | Head entry present |
| rd_ready | input | 1 | Framer takes the head entry |
| rd_data | output | 8 | Head data byte, bit 0 sent first |
| rd_eom | output | 1 | Head entry closes a message |
| wm_sel | input | 3 | Low-watermark threshold select |
| stat_rd | input | 1 | Status read strobe, clears `pkt_end` |
| mask_pkt_end | input | 1 | Interrupt enable for `pkt_end` |
| mask_low_wm | input | 1 | Interrupt enable for `low_wm` |
| mask_global | input | 1 | Global interrupt enable |
| pkt_end | output | 1 | Latched message-end / underrun event |
| low_wm | output | 1 | Live low-watermark flag |
| empty | output | 1 | Live empty flag |
| fill_lvl | output | 4 | Coarse fill level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is a pop and a commit in the same cycle while the queue is exactly full, because it needs all 256 entries written first. The bench fills the queue with a computed pattern and checks the level and watermark flags at every count for every threshold setting on the way up. It then issues the simultaneous pop and commit and drains everything. The drained sequence must match the model exactly, which proves that neither rejected byte slipped in. The set-wins case of the packet-end flag is reached by raising `rd_ready` on an empty queue in the same cycle as a status read.

// File: rtl/hdlc_txq_pkg.sv
package hdlc_txq_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              eom;
    logic [BYTE_W-1:0] data;
  } txq_entry_t;
endpackage

// File: rtl/txq_wr_assemble.sv
module txq_wr_assemble
  import hdlc_txq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus8,
  input  logic        wr_valid,
  input  logic        wr_hi,
  input  logic [15:0] wr_data,
  output logic        commit,
  output txq_entry_t  entry
);
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lo_q <= '0;
    else if (wr_valid && bus8 && !wr_hi) lo_q <= wr_data[BYTE_W-1:0];
  end

  always_comb begin
    commit = wr_valid && (!bus8 || wr_hi);
    if (bus8) begin
      entry.data = lo_q;
      entry.eom  = wr_data[0];
    end else begin
      entry.data = wr_data[BYTE_W-1:0];
      entry.eom  = wr_data[BYTE_W];
    end
  end
endmodule

// File: rtl/txq_store.sv
module txq_store
  import hdlc_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  txq_entry_t    push_entry,
  input  logic          pop_req,
  output txq_entry_t    head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          is_empty
);
  txq_entry_t    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push, pop;

  assign full     = (count == CW'(DEPTH));
  assign is_empty = (count == '0);
  assign push     = push_req && !full;
  assign pop      = pop_req && !is_empty;
  assign head     = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/txq_status.sv
module txq_status #(
  parameter int unsigned CW      = 9,
  parameter int unsigned WM_W    = 3,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned WM_STEP = 16,
  localparam int unsigned TW      = CW + WM_W,
  localparam int unsigned STEP_SH = $clog2(WM_STEP),
  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    count,
  input  logic [WM_W-1:0]  wm_sel,
  input  logic             pop_eom,
  input  logic             underrun,
  input  logic             stat_rd,
  input  logic             mask_pkt_end,
  input  logic             mask_low_wm,
  input  logic             mask_global,
  output logic             pkt_end,
  output logic             low_wm,
  output logic [LVL_W-1:0] fill_lvl,
  output logic             irq
);
  logic [TW-1:0] thresh;
  logic [CW-1:0] coarse;

  always_ff @(posedge clk) begin
    if (!rst_n)                   pkt_end <= 1'b0;
    else if (pop_eom || underrun) pkt_end <= 1'b1;
    else if (stat_rd)             pkt_end <= 1'b0;
  end

  always_comb begin
    thresh   = TW'((TW'(wm_sel) + 1'b1) << STEP_SH);
    low_wm   = TW'(count) < thresh;
    coarse   = count >> STEP_SH;
    fill_lvl = (coarse > CW'(LVL_MAX)) ? LVL_W'(LVL_MAX) : LVL_W'(coarse);
    irq      = mask_global && ((pkt_end && mask_pkt_end) || (low_wm && mask_low_wm));
  end
endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
  import hdlc_txq_pkg::*;
#(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned WM_W    = 3,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned WM_STEP = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus8,
  input  logic             wr_valid,
  input  logic             wr_hi,
  input  logic [15:0]      wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             rd_eom,
  input  logic [WM_W-1:0]  wm_sel,
  input  logic             stat_rd,
  input  logic             mask_pkt_end,
  input  logic             mask_low_wm,
  input  logic             mask_global,
  output logic             pkt_end,
  output logic             low_wm,
  output logic             empty,
  output logic [LVL_W-1:0] fill_lvl,
  output logic             irq
);
  logic          commit, full, is_empty;
  txq_entry_t    new_entry, head;
  logic [CW-1:0] cnt;

  txq_wr_assemble u_asm (
    .clk(clk), .rst_n(rst_n), .bus8(bus8), .wr_valid(wr_valid),
    .wr_hi(wr_hi), .wr_data(wr_data), .commit(commit), .entry(new_entry)
  );

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_req(commit), .push_entry(new_entry),
    .pop_req(rd_ready), .head(head), .count(cnt), .full(full), .is_empty(is_empty)
  );

  assign wr_ready = !full;
  assign rd_valid = !is_empty;
  assign empty    = is_empty;
  assign rd_data  = head.data;
  assign rd_eom   = head.eom;

  txq_status #(.CW(CW), .WM_W(WM_W), .LVL_W(LVL_W), .WM_STEP(WM_STEP)) u_stat (
    .clk(clk), .rst_n(rst_n), .count(cnt), .wm_sel(wm_sel),
    .pop_eom(rd_ready && !is_empty && head.eom),
    .underrun(rd_ready && is_empty), .stat_rd(stat_rd),
    .mask_pkt_end(mask_pkt_end), .mask_low_wm(mask_low_wm), .mask_global(mask_global),
    .pkt_end(pkt_end), .low_wm(low_wm), .fill_lvl(fill_lvl), .irq(irq)
  );
endmodule

// File: rtl/hdlc_tx_fifo_chk.sv
module hdlc_tx_fifo_chk #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rd_eom,
  input logic          stat_rd,
  input logic          pkt_end,
  input logic          mask_global,
  input logic          irq,
  input logic [CW-1:0] cnt
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !(rd_valid && rd_ready)) |=> $stable(cnt));

  assert_eom_pop_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_eom) |=> pkt_end);

  assert_underrun_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid) |=> pkt_end);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rd_ready) |=> !pkt_end);

  assert_global_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_global);
endmodule

bind hdlc_tx_fifo hdlc_tx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_eom(rd_eom), .stat_rd(stat_rd), .pkt_end(pkt_end),
  .mask_global(mask_global), .irq(irq), .cnt(cnt)
);

// File: tb/hdlc_tx_fifo_tb.sv
module hdlc_tx_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus8 = 1'b0, wr_valid = 1'b0, wr_hi = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_ready, rd_valid, rd_eom, pkt_end, low_wm, empty, irq;
  logic        rd_ready = 1'b0, stat_rd = 1'b0;
  logic [7:0]  rd_data;
  logic [2:0]  wm_sel = '0;
  logic        mask_pkt_end = 1'b0, mask_low_wm = 1'b0, mask_global = 1'b0;
  logic [3:0]  fill_lvl;

  int n_chk = 0, n_bad = 0;
  logic [8:0] model [0:511];
  int wp = 0, rp = 0;

  always #10 clk = ~clk;

  hdlc_tx_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .bus8(bus8), .wr_valid(wr_valid), .wr_hi(wr_hi),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_eom(rd_eom), .wm_sel(wm_sel), .stat_rd(stat_rd),
    .mask_pkt_end(mask_pkt_end), .mask_low_wm(mask_low_wm), .mask_global(mask_global),
    .pkt_end(pkt_end), .low_wm(low_wm), .empty(empty), .fill_lvl(fill_lvl), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push16(input logic [7:0] d, input logic tag);
    bus8 = 1'b0; wr_valid = 1'b1;
    wr_data = {7'h55, tag, d};
    step();
    wr_valid = 1'b0;
  endtask

  task automatic level_sweep(input int cnt);
    check("R8 fill_lvl", fill_lvl, (cnt / 16 > 15) ? 15 : cnt / 16);
    check("R8 empty", empty, cnt == 0);
    for (int s = 0; s < 8; s++) begin
      wm_sel = 3'(s); #1;
      check("R7 low_wm", low_wm, cnt < 16 * (s + 1));
    end
    wm_sel = '0;
  endtask

  task automatic irq_sweep(input int pe, input int lw);
    for (int m = 0; m < 8; m++) begin
      mask_global = m[2]; mask_pkt_end = m[1]; mask_low_wm = m[0]; #1;
      check("R9 irq", irq, m[2] & ((pe & m[1]) | (lw & m[0])));
    end
    mask_global = 1'b0; mask_pkt_end = 1'b0; mask_low_wm = 1'b0;
  endtask

  task automatic clear_evt();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    check("R6 cleared by read", pkt_end, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1; #1;
    check("R8 reset empty", empty, 1);
    check("R1 reset rd_valid", rd_valid, 0);
    check("R2 reset wr_ready", wr_ready, 1);
    check("R5 reset pkt_end", pkt_end, 0);
    level_sweep(0);
    irq_sweep(0, 1);

    // R3 fill to capacity with 16-bit writes
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      logic       t;
      d = 8'((i * 37 + 11) & 255);
      t = (i % 7 == 6);
      push16(d, t);
      model[wp] = {t, d}; wp++;
      level_sweep(i + 1);
    end
    check("R2 full wr_ready", wr_ready, 0);
    irq_sweep(0, 0);

    // R2 write at full is dropped
    push16(8'hEE, 1'b1);
    check("R2 full still", wr_ready, 0);
    check("R2 level unchanged", fill_lvl, 15);

    // R2 simultaneous pop and commit while full
    check("R1 head data", rd_data, model[rp][7:0]);
    rd_ready = 1'b1; wr_valid = 1'b1; wr_data = 16'h0066;
    step();
    rd_ready = 1'b0; wr_valid = 1'b0;
    rp++;
    check("R2 pop taken, write dropped", wr_ready, 1);
    clear_evt();

    // R1 R5 R6 drain in order
    while (rp < wp) begin
      check("R1 rd_valid", rd_valid, 1);
      check("R1 head data", rd_data, model[rp][7:0]);
      check("R1 head tag", rd_eom, model[rp][8]);
      rd_ready = 1'b1; step(); rd_ready = 1'b0;
      check("R5 tag sets pkt_end", pkt_end, model[rp][8]);
      rp++;
      if (pkt_end) begin
        irq_sweep(1, (wp - rp) < 16);
        clear_evt();
      end
    end
    check("R1 drained empty", empty, 1);
    check("R2 no stray entry", rd_valid, 0);

    // R5 underrun, R6 set wins over read
    rd_ready = 1'b1; step();
    check("R5 underrun sets", pkt_end, 1);
    irq_sweep(1, 1);
    stat_rd = 1'b1; step();
    rd_ready = 1'b0; stat_rd = 1'b0;
    check("R6 set wins over read", pkt_end, 1);
    clear_evt();

    // R4 8-bit mode assembly
    bus8 = 1'b1; wr_valid = 1'b1; wr_hi = 1'b0; wr_data = 16'hFFA5;
    step();
    check("R4 low write commits nothing", empty, 1);
    wr_hi = 1'b1; wr_data = 16'h0001;
    step();
    wr_hi = 1'b0; wr_data = 16'h003C;
    step();
    wr_hi = 1'b1; wr_data = 16'h01FE;
    step();
    wr_valid = 1'b0; wr_hi = 1'b0; bus8 = 1'b0;
    check("R4 two entries", fill_lvl, 0);
    check("R4 first data", rd_data, 8'hA5);
    check("R4 first tag", rd_eom, 1);
    rd_ready = 1'b1; step(); rd_ready = 1'b0;
    check("R5 narrow tag pop", pkt_end, 1);
    check("R4 second data", rd_data, 8'h3C);
    check("R4 second tag", rd_eom, 0);
    stat_rd = 1'b1; rd_ready = 1'b1; step(); stat_rd = 1'b0; rd_ready = 1'b0;
    check("R6 clear on untagged pop", pkt_end, 0);
    check("R4 empty after", empty, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule